// File: doc/BRIEF.md
# Line-Organized Reorder Buffer

This block keeps in-flight micro-operations in program order between a decode stage and the retirement point. Decode offers a group of up to three operations per cycle. The group is stored as one line of three slots in a circular buffer of 24 lines, so at most 72 operations can be in flight. Integer and floating-point operations share the same buffer. Each stored slot carries a destination identifier, a completion bit and two fault bits: exception and branch mispredict. Execution units report completion through a writeback port. The report is addressed by the tag that the buffer returned when the line was accepted.

Retirement works on whole lines from the head, at most one per cycle. A line leaves only when all of its relevant slots have completed. If the head line contains a faulting slot, the slots older than the fault retire. The faulting slot and everything younger are then discarded, the buffer is emptied in a single cycle, and a one-cycle redirect names the faulting tag. Allocation is a valid/ready handshake. The group is accepted on a cycle where both are high, and ready falls whenever no free line is left or a redirect is being signalled. The retirement and redirect outputs are plain status that apply back-pressure to nothing: a consumer must take them in the cycle they appear.

Top module: `line_rob`

## Requirements
- R1: A group is accepted when alloc_valid and alloc_ready are both high at a rising edge. alloc_mask bit s marks slot s as holding an operation, where slot 0 is the oldest. The mask must not be zero. The destination for slot s is carried on alloc_dest bits [s*6 +: 6] and is returned unchanged on retire_dest at the same position.
- R2: Every accepted group occupies exactly one line, even when it has fewer than three operations. Slots not set in the mask are invalid. alloc_line shows the index that the next accepted line receives. Indices start at 0 after reset, advance by one per accepted line, and wrap from 23 to 0. retire_line reports the index of the retiring line.
- R3: The completion tag is {line index (5 bits), slot index (2 bits)}, with slot values 0 to 2. A wb_valid cycle marks that slot complete. It also records wb_exc and wb_misp as the slot's exception and mispredict flags.
- R4: While the head line has every valid slot complete and no fault flag, retire_valid is high in that cycle. retire_mask then equals the line's valid slots. The line is freed at the next edge. Lines retire in allocation order, one per cycle at most.
- R5: Retirement never waits on a downstream signal. A line that becomes eligible is presented and freed without any acknowledgement.
- R6: alloc_ready is low when all 24 lines are occupied, and low in any cycle where redirect is high. It is high otherwise.
- R7: The fault slot is the lowest valid slot of the head line with a flag set. Once every valid slot below it has completed, redirect is high for that cycle. redirect_tag gives the fault slot's tag. redirect_exc is 1 if that slot's exception flag is set and 0 if only mispredict is set.
- R8: After a redirect cycle the buffer is empty and redirect is low. Writebacks and allocation offered in the redirect cycle have no effect. The next accepted line takes the index that alloc_line showed before the redirect.
- R9: In a redirect cycle, retire_valid is high only if valid slots exist below the fault slot, and retire_mask holds exactly those slots. The fault slot and any younger slot never retire, even if they have completed.
- R10: After reset the buffer is empty. alloc_ready is high, retire_valid and redirect are low, and alloc_line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers a group |
| alloc_ready | output | 1 | A free line exists and no redirect is in progress |
| alloc_mask | input | 3 | Valid slots of the offered group |
| alloc_dest | input | 18 | Destination identifier per slot |
| alloc_line | output | 5 | Line index that the offered group receives |
| wb_valid | input | 1 | Completion report |
| wb_tag | input | 7 | {line, slot} of the completing entry |
| wb_exc | input | 1 | Completing entry raised an exception |
| wb_misp | input | 1 | Completing entry was a mispredicted branch |
| retire_valid | output | 1 | Head line slots are retiring this cycle |
| retire_mask | output | 3 | Slots that retire |
| retire_dest | output | 18 | Destinations of the head line |
| retire_line | output | 5 | Index of the head line |
| redirect | output | 1 | Flush and redirect pulse |
| redirect_exc | output | 1 | Cause of the redirect: 1 for exception, 0 for mispredict |
| redirect_tag | output | 7 | Tag of the faulting entry |

## Verification
The assertions assume that decode never offers an empty mask. They also assume that writebacks name only live entries that have not yet completed, and that each entry completes once. A writeback to a freed or unallocated line, or a second completion of the same entry, is outside the contract. The stimulus keeps to these rules by building each mask as a non-zero random value. It draws writeback targets only from the reference model's list of live, incomplete slots, and the model marks each slot complete at the edge where the writeback is taken. The fault rate, writeback rate and allocation rate are varied across phases, so the full-buffer stall, dense fault sequences and quiet draining are all reached.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Per-slot progress record stored in every line.
  typedef struct packed {
    logic done;
    logic exc;
    logic misp;
  } slot_st_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int NLINES = 24,
  parameter int LW     = 5,
  parameter int OW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [LW-1:0] head,
  output logic [LW-1:0] tail,
  output logic [OW-1:0] occ
);

  function automatic logic [LW-1:0] step(input logic [LW-1:0] p);
    return (p == LW'(NLINES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (flush) begin
      // Discard every line: head catches up with tail.
      head <= tail;
      occ  <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      occ <= occ + OW'(push) - OW'(pop);
    end
  end

endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int NLINES = 24,
  parameter int SLOTS  = 3,
  parameter int DEST_W = 6,
  parameter int LW     = 5,
  parameter int SW     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [LW-1:0]             tail,
  input  logic [SLOTS-1:0]          mask,
  input  logic [SLOTS*DEST_W-1:0]   dest,
  input  logic                      wb_en,
  input  logic [LW-1:0]             wb_line,
  input  logic [SW-1:0]             wb_slot,
  input  logic                      wb_exc,
  input  logic                      wb_misp,
  input  logic [LW-1:0]             head,
  output logic [SLOTS-1:0]          head_vld,
  output slot_st_t [SLOTS-1:0]      head_st,
  output logic [SLOTS*DEST_W-1:0]   head_dst
);

  logic [SLOTS-1:0]        vld_q [NLINES];
  slot_st_t [SLOTS-1:0]    st_q  [NLINES];
  logic [SLOTS*DEST_W-1:0] dst_q [NLINES];

  logic wb_hit;
  assign wb_hit = wb_en && (int'(wb_slot) < SLOTS) && (int'(wb_line) < NLINES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NLINES; l++) begin
        vld_q[l] <= '0;
        st_q[l]  <= '0;
      end
    end else begin
      if (wb_hit) begin
        st_q[wb_line][wb_slot].done <= 1'b1;
        st_q[wb_line][wb_slot].exc  <= st_q[wb_line][wb_slot].exc  | wb_exc;
        st_q[wb_line][wb_slot].misp <= st_q[wb_line][wb_slot].misp | wb_misp;
      end
      // A fresh line overrides any stale report aimed at the same index.
      if (push) begin
        vld_q[tail] <= mask;
        st_q[tail]  <= '0;
        dst_q[tail] <= dest;
      end
    end
  end

  assign head_vld = vld_q[head];
  assign head_st  = st_q[head];
  assign head_dst = dst_q[head];

endmodule

// File: rtl/rob_head_eval.sv
module rob_head_eval
  import rob_pkg::*;
#(
  parameter int SLOTS = 3,
  parameter int SW    = 2
) (
  input  logic                 nonempty,
  input  logic [SLOTS-1:0]     vld,
  input  slot_st_t [SLOTS-1:0] st,
  output logic                 eligible,
  output logic                 fault,
  output logic [SW-1:0]        fslot,
  output logic                 fexc,
  output logic [SLOTS-1:0]     keep
);

  logic blk;
  logic ok;

  // Walk the slots oldest first; stop counting at the first flagged slot.
  always_comb begin
    blk   = 1'b0;
    ok    = 1'b1;
    fslot = '0;
    fexc  = 1'b0;
    keep  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (vld[s] && !blk) begin
        if (!st[s].done) ok = 1'b0;
        if (st[s].exc || st[s].misp) begin
          blk   = 1'b1;
          fslot = SW'(s);
          fexc  = st[s].exc;
        end else begin
          keep[s] = 1'b1;
        end
      end
    end
    eligible = nonempty && ok;
    fault    = blk;
  end

endmodule

// File: rtl/line_rob.sv
module line_rob
  import rob_pkg::*;
#(
  parameter  int NLINES = 24,
  parameter  int SLOTS  = 3,
  parameter  int DEST_W = 6,
  localparam int LW     = $clog2(NLINES),
  localparam int SW     = $clog2(SLOTS),
  localparam int OW     = $clog2(NLINES + 1),
  localparam int TW     = LW + SW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  output logic                    alloc_ready,
  input  logic [SLOTS-1:0]        alloc_mask,
  input  logic [SLOTS*DEST_W-1:0] alloc_dest,
  output logic [LW-1:0]           alloc_line,
  input  logic                    wb_valid,
  input  logic [TW-1:0]           wb_tag,
  input  logic                    wb_exc,
  input  logic                    wb_misp,
  output logic                    retire_valid,
  output logic [SLOTS-1:0]        retire_mask,
  output logic [SLOTS*DEST_W-1:0] retire_dest,
  output logic [LW-1:0]           retire_line,
  output logic                    redirect,
  output logic                    redirect_exc,
  output logic [TW-1:0]           redirect_tag
);

  localparam logic [OW-1:0] FULL = OW'(NLINES);

  logic [LW-1:0]        head, tail;
  logic [OW-1:0]        occ;
  logic                 push, pop, flush, wb_en;
  logic [SLOTS-1:0]     head_vld, keep;
  slot_st_t [SLOTS-1:0] head_st;
  logic                 eligible, fault, fexc;
  logic [SW-1:0]        fslot;

  assign flush       = eligible && fault;
  assign pop         = eligible && !fault;
  assign alloc_ready = (occ < FULL) && !flush;
  assign push        = alloc_valid && alloc_ready;
  assign wb_en       = wb_valid && !flush;

  rob_ptrs #(.NLINES(NLINES), .LW(LW), .OW(OW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .head(head), .tail(tail), .occ(occ)
  );

  rob_store #(.NLINES(NLINES), .SLOTS(SLOTS), .DEST_W(DEST_W), .LW(LW), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .tail(tail), .mask(alloc_mask),
    .dest(alloc_dest), .wb_en(wb_en), .wb_line(wb_tag[TW-1:SW]),
    .wb_slot(wb_tag[SW-1:0]), .wb_exc(wb_exc), .wb_misp(wb_misp),
    .head(head), .head_vld(head_vld), .head_st(head_st), .head_dst(retire_dest)
  );

  rob_head_eval #(.SLOTS(SLOTS), .SW(SW)) u_eval (
    .nonempty(occ != '0), .vld(head_vld), .st(head_st),
    .eligible(eligible), .fault(fault), .fslot(fslot), .fexc(fexc), .keep(keep)
  );

  assign alloc_line   = tail;
  assign retire_valid = eligible && (keep != '0);
  assign retire_mask  = keep;
  assign retire_line  = head;
  assign redirect     = flush;
  assign redirect_exc = fexc;
  assign redirect_tag = {head, fslot};

endmodule

// File: rtl/rob_check.sv
module rob_check #(
  parameter  int NLINES = 24,
  parameter  int SLOTS  = 3,
  localparam int OW     = $clog2(NLINES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [SLOTS-1:0] alloc_mask,
  input logic             retire_valid,
  input logic             redirect,
  input logic [OW-1:0]    occ
);

  localparam logic [OW-1:0] FULL = OW'(NLINES);

  // R1: decode never offers an empty group
  a_r1_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (alloc_mask != '0));

  // R6: no acceptance when every line is taken
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL) |-> !alloc_ready);

  // R6: occupancy never exceeds the line count
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);

  // R4: a plain retirement frees exactly one line
  a_r4_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !redirect) |=>
      occ == $past(occ) + OW'($past(alloc_valid && alloc_ready)) - OW'(1));

  // R8: redirect lasts one cycle
  a_r8_redirect_single: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  // R8: buffer is empty after a redirect
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (occ == '0));

  // R10: an empty buffer retires nothing
  a_r10_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (!retire_valid && !redirect));

endmodule

bind line_rob rob_check #(.NLINES(NLINES), .SLOTS(SLOTS)) u_rob_check (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_mask(alloc_mask), .retire_valid(retire_valid), .redirect(redirect), .occ(occ)
);

// File: tb/test_line_rob.sv
module test_line_rob;
  localparam int NL = 24;
  localparam int DW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [2:0]  alloc_mask = 3'b001;
  logic [17:0] alloc_dest = '0;
  logic [4:0]  alloc_line;
  logic        wb_valid = 1'b0;
  logic [6:0]  wb_tag = '0;
  logic        wb_exc = 1'b0;
  logic        wb_misp = 1'b0;
  logic        retire_valid;
  logic [2:0]  retire_mask;
  logic [17:0] retire_dest;
  logic [4:0]  retire_line;
  logic        redirect;
  logic        redirect_exc;
  logic [6:0]  redirect_tag;

  always #2 clk = ~clk;

  line_rob i_line_rob (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_mask(alloc_mask), .alloc_dest(alloc_dest), .alloc_line(alloc_line),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_exc(wb_exc), .wb_misp(wb_misp),
    .retire_valid(retire_valid), .retire_mask(retire_mask), .retire_dest(retire_dest),
    .retire_line(retire_line), .redirect(redirect), .redirect_exc(redirect_exc),
    .redirect_tag(redirect_tag)
  );

  typedef struct packed {
    logic [4:0]  line;
    logic [2:0]  v;
    logic [2:0]  d;
    logic [2:0]  e;
    logic [2:0]  m;
    logic [17:0] dst;
  } lrec_t;

  lrec_t lq[$];
  int  mt = 0;
  int  nchk = 0;
  int  nfail = 0;
  int  arate = 0, wrate = 0, frate = 0;
  bit  run = 0;
  bit  last_red = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural view of the head line.
  function automatic void head_eval(output bit el, output bit flt, output int fs,
                                    output bit fx, output logic [2:0] km);
    bit ok = 1;
    el = 0; flt = 0; fs = 0; fx = 0; km = '0;
    if (lq.size() == 0) return;
    for (int s = 0; s < 3; s++) begin
      if (lq[0].v[s] && !flt) begin
        if (!lq[0].d[s]) ok = 0;
        if (lq[0].e[s] || lq[0].m[s]) begin
          flt = 1; fs = s; fx = lq[0].e[s];
        end else km[s] = 1'b1;
      end
    end
    el = ok;
  endfunction

  // Model update at the clock edge.
  always @(posedge clk) begin
    if (rst_n && run) begin
      bit el, flt, fx; int fs; logic [2:0] km;
      bit red, rdy;
      lrec_t r;
      head_eval(el, flt, fs, fx, km);
      red = el && flt;
      rdy = (lq.size() < NL) && !red;
      if (red) lq.delete();
      else if (el) r = lq.pop_front();
      if (wb_valid && !red) begin
        for (int i = 0; i < lq.size(); i++) begin
          if (lq[i].line == wb_tag[6:2]) begin
            lq[i].d[wb_tag[1:0]] = 1'b1;
            lq[i].e[wb_tag[1:0]] = lq[i].e[wb_tag[1:0]] | wb_exc;
            lq[i].m[wb_tag[1:0]] = lq[i].m[wb_tag[1:0]] | wb_misp;
          end
        end
      end
      if (alloc_valid && rdy) begin
        r.line = 5'(mt); r.v = alloc_mask; r.d = '0; r.e = '0; r.m = '0; r.dst = alloc_dest;
        lq.push_back(r);
        mt = (mt + 1) % NL;
      end
    end
  end

  // Compare and drive away from the active edge.
  always @(negedge clk) begin
    if (rst_n && run) begin
      bit el, flt, fx; int fs; logic [2:0] km;
      bit ered, erv, erdy;
      int cl[$], cs[$];
      int rr;
      head_eval(el, flt, fs, fx, km);
      ered = el && flt;
      erv  = el && (km != 0);
      erdy = (lq.size() < NL) && !ered;
      chk(alloc_ready == erdy, "R6", "alloc_ready", alloc_ready, erdy);
      if (erdy) chk(alloc_line == 5'(mt), last_red ? "R8" : "R2", "alloc_line", alloc_line, mt);
      chk(retire_valid == erv, "R4 R5 R3", "retire_valid", retire_valid, erv);
      if (erv && retire_valid) begin
        chk(retire_mask == km, "R9", "retire_mask", retire_mask, km);
        chk(retire_line == lq[0].line, "R2", "retire_line", retire_line, lq[0].line);
        for (int s = 0; s < 3; s++)
          if (km[s]) chk(retire_dest[s*DW +: DW] == lq[0].dst[s*DW +: DW], "R1",
                         "retire_dest", retire_dest[s*DW +: DW], lq[0].dst[s*DW +: DW]);
      end
      chk(redirect == ered, "R7", "redirect", redirect, ered);
      if (ered && redirect) begin
        chk(redirect_tag == {lq[0].line, 2'(fs)}, "R7", "redirect_tag", redirect_tag,
            {lq[0].line, 2'(fs)});
        chk(redirect_exc == fx, "R7", "redirect_exc", redirect_exc, fx);
      end
      last_red = ered;

      // Next stimulus.
      alloc_valid = ($urandom % 100) < arate;
      alloc_mask  = 3'(1 + ($urandom % 7));
      alloc_dest  = 18'($urandom);
      for (int i = 0; i < lq.size(); i++)
        for (int s = 0; s < 3; s++)
          if (lq[i].v[s] && !lq[i].d[s]) begin cl.push_back(i); cs.push_back(s); end
      if (cl.size() > 0 && ($urandom % 100) < wrate) begin
        int k;
        k = $urandom % cl.size();
        wb_valid = 1'b1;
        wb_tag   = {lq[cl[k]].line, 2'(cs[k])};
        rr       = $urandom % 1000;
        wb_exc   = (rr < frate) && (rr % 2 == 0);
        wb_misp  = (rr < frate) && (rr % 2 == 1);
      end else begin
        wb_valid = 1'b0; wb_exc = 1'b0; wb_misp = 1'b0;
      end
    end
  end

  task automatic phase(input int a, input int w, input int f, input int cyc);
    arate = a; wrate = w; frate = f;
    repeat (cyc) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(alloc_ready == 1'b1 || alloc_ready == 1'b0, "R10", "ready known in reset", alloc_ready, alloc_ready);
    rst_n = 1'b1;
    #0.5;
    chk(alloc_ready == 1'b1, "R10", "alloc_ready after reset", alloc_ready, 1);
    chk(retire_valid == 1'b0, "R10", "retire_valid after reset", retire_valid, 0);
    chk(redirect == 1'b0, "R10", "redirect after reset", redirect, 0);
    chk(alloc_line == 5'd0, "R10", "alloc_line after reset", alloc_line, 0);
    run = 1;
    phase(70, 80, 0, 400);     // steady flow
    phase(100, 0, 0, 40);      // fill to full, R6 stall
    phase(100, 100, 0, 300);   // drain under pressure
    phase(60, 70, 30, 3000);   // occasional faults
    phase(90, 90, 300, 1000);  // dense faults
    phase(50, 60, 10, 2000);   // mixed
    phase(0, 100, 0, 300);     // drain
    @(negedge clk);
    run = 0;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

endmodule